// File: doc/BRIEF.md
# Row-column decoded byte RAM

This block is a small on-chip byte store of 256 cells, each 8 bits wide, arranged as a 16-by-16 grid. A dedicated address register holds the cell being accessed. It is loaded only when its own load strobe is high. The register's high nibble selects one row line and its low nibble selects one column line, and each decoder drives exactly one line. A cell counts as active only where its row line and its column line cross.

Two global strobes drive all accesses. The write strobe is ANDed with each cell's active signal, so only the active cell captures the shared input byte. The read strobe is ANDed in the same way, so only the active cell places its byte on the output. The output is the OR of every cell's gated byte, and it reads zero when the read strobe is low.

A write takes three steps: load the address, present the data, then pulse the write strobe. A read takes two steps: load the address, then hold the read strobe and observe the output in the same cycle. All state changes on the rising clock edge. The active-low reset is asynchronous.

Top module: `grid_byte_ram`

## Requirements
- R1: After reset, the address register holds 0, every cell holds 0, and a read of any cell returns 0.
- R2: On a rising edge with `addr_load` high, the address register takes `addr_in`. With `addr_load` low, changes on `addr_in` do not change the selected cell.
- R3: The address register's bits [3:0] pick the column and bits [7:4] pick the row. Each decoder has exactly one output high at all times, including at the nibble boundaries 0x01, 0x0F, 0x10 and 0xF0.
- R4: Exactly the cell at the crossing of the high row line and the high column line is selected. Its index is row*16+column, which equals the held address, and at most one cell drives the output.
- R5: On a rising edge with `io_set` high, the selected cell captures `io_in`, and every other cell keeps its value.
- R6: While `io_en` is high, `io_out` equals the byte of the selected cell in the same cycle, with no register in the read path.
- R7: While `io_en` is low, `io_out` is 0.
- R8: With `io_set` and `io_en` both high, `io_out` shows the selected cell's old byte during that cycle. The cell holds the new byte from the next cycle on.
- R9: With `io_set` low, `io_in` has no effect on any cell.
- R10: When `addr_load` and `io_set` are high in the same cycle, the write goes to the address held before that edge, and the new address takes effect for the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 8 | Address presented to the address register |
| addr_load | input | 1 | Loads `addr_in` into the address register at the clock edge |
| io_set | input | 1 | Global write strobe, gated per cell by its select |
| io_en | input | 1 | Global read strobe, gated per cell by its select |
| io_in | input | 8 | Write data shared by all cells |
| io_out | output | 8 | OR of all gated cell bytes |

## Verification
The bench builds the block with its default parameters: 8-bit data and 4 row and 4 column address bits. At that size it writes a distinct byte into every one of the 256 cells and reads each one back, which drives every row line and every column line of both decoders within the run. A behavioural model, made of an array and a held address, predicts `io_out` before every clock edge. Directed cycles target the ordering corners: a load and a write in the same cycle, a read and a write in the same cycle, and strobes held low while `addr_in` and `io_in` change.

// File: rtl/gbr_pkg.sv
`timescale 1ns/1ps
package gbr_pkg;

    // Access kind formed as {io_set, io_en}; the position of each strobe is fixed.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_SWAP  = 2'b11
    } acc_kind_t;

endpackage

// File: rtl/gbr_addr_reg.sv
`timescale 1ns/1ps
module gbr_addr_reg #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/gbr_onehot_dec.sv
`timescale 1ns/1ps
module gbr_onehot_dec #(
    parameter int SW = 4,
    localparam int N = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  hot
);

    always_comb begin
        hot      = '0;
        hot[sel] = 1'b1;
    end

    // R3
    single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hot) == 1);

endmodule

// File: rtl/gbr_cell.sv
`timescale 1ns/1ps
module gbr_cell #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_sel,
    input  logic          col_sel,
    input  logic          wr_glob,
    input  logic          rd_glob,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe_o
);

    logic          active;
    logic          we;
    logic [DW-1:0] held;

    assign active = row_sel & col_sel;
    assign we     = active & wr_glob;
    assign oe_o   = active & rd_glob;
    assign dout   = oe_o ? held : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (we) begin
            held <= din;
        end
    end

    // R5
    cell_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (held == $past(din)));

    // R9
    cell_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(held));

endmodule

// File: rtl/grid_byte_ram.sv
`timescale 1ns/1ps
module grid_byte_ram #(
    parameter int DATA_W   = 8,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ROW_BITS+COL_BITS-1:0] addr_in,
    input  logic                         addr_load,
    input  logic                         io_set,
    input  logic                         io_en,
    input  logic [DATA_W-1:0]            io_in,
    output logic [DATA_W-1:0]            io_out
);
    import gbr_pkg::*;

    localparam int ADDR_W = ROW_BITS + COL_BITS;
    localparam int ROWS   = 1 << ROW_BITS;
    localparam int COLS   = 1 << COL_BITS;
    localparam int CELLS  = ROWS * COLS;

    logic [ADDR_W-1:0] addr_q;
    logic [ROWS-1:0]   row_hot;
    logic [COLS-1:0]   col_hot;
    logic              wr_glob;
    logic              rd_glob;
    acc_kind_t         kind;
    logic [DATA_W-1:0] cell_q [CELLS];
    logic [CELLS-1:0]  cell_oe;

    gbr_addr_reg #(.AW(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (addr_load),
        .d     (addr_in),
        .q     (addr_q)
    );

    gbr_onehot_dec #(.SW(ROW_BITS)) u_row_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (addr_q[ADDR_W-1:COL_BITS]),
        .hot   (row_hot)
    );

    gbr_onehot_dec #(.SW(COL_BITS)) u_col_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (addr_q[COL_BITS-1:0]),
        .hot   (col_hot)
    );

    assign kind = acc_kind_t'({io_set, io_en});

    always_comb begin
        wr_glob = 1'b0;
        rd_glob = 1'b0;
        unique case (kind)
            ACC_IDLE:  begin wr_glob = 1'b0; rd_glob = 1'b0; end
            ACC_READ:  begin wr_glob = 1'b0; rd_glob = 1'b1; end
            ACC_WRITE: begin wr_glob = 1'b1; rd_glob = 1'b0; end
            ACC_SWAP:  begin wr_glob = 1'b1; rd_glob = 1'b1; end
            default:   begin wr_glob = 1'b0; rd_glob = 1'b0; end
        endcase
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            gbr_cell #(.DW(DATA_W)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .row_sel (row_hot[r]),
                .col_sel (col_hot[c]),
                .wr_glob (wr_glob),
                .rd_glob (rd_glob),
                .din     (io_in),
                .dout    (cell_q[IDX]),
                .oe_o    (cell_oe[IDX])
            );
        end
    end

    always_comb begin
        io_out = '0;
        for (int k = 0; k < CELLS; k++) begin
            io_out = io_out | cell_q[k];
        end
    end

    // R4
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_oe));

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> (io_out == '0));

    // R6
    read_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> ($countones(cell_oe) == 1));

endmodule

// File: tb/sim_grid_byte_ram.sv
`timescale 1ns/1ps
module sim_grid_byte_ram;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_in = '0;
    logic       addr_load = 1'b0;
    logic       io_set = 1'b0;
    logic       io_en = 1'b0;
    logic [7:0] io_in = '0;
    logic [7:0] io_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_addr;

    always #2 clk = ~clk;

    grid_byte_ram u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr_in),
        .addr_load (addr_load),
        .io_set    (io_set),
        .io_en     (io_en),
        .io_in     (io_in),
        .io_out    (io_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s io_out actual %02h expected %02h (model addr %02h)",
                     tag, got, exp, ref_addr);
        end
    endtask

    // One clock: drive after the falling edge, compare before the rising edge, then advance the model.
    task automatic cyc(input logic ld, input logic [7:0] a, input logic s,
                       input logic e, input logic [7:0] d, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        addr_load = ld;
        addr_in   = a;
        io_set    = s;
        io_en     = e;
        io_in     = d;
        #1;
        exp = e ? ref_mem[ref_addr] : 8'h00;
        check(tag, io_out, exp);
        @(posedge clk);
        if (s) ref_mem[ref_addr] = d;
        if (ld) ref_addr = a;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11) ^ 8'h5A;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ref_addr = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, default cell 0 and every cell reads zero
        cyc(0, 8'hAB, 0, 1, 8'h00, "R1");
        for (int a = 0; a < 256; a++) begin
            cyc(1, 8'(a), 0, 0, 8'h00, "R1");
            cyc(0, 8'h00, 0, 1, 8'h00, "R1");
        end

        // R5: a distinct byte into every cell
        for (int a = 0; a < 256; a++) begin
            cyc(1, 8'(a), 0, 0, 8'h00, "R2");
            cyc(0, 8'h00, 1, 0, pat(a), "R5");
        end

        // R4 and R6: read every cell back
        for (int a = 255; a >= 0; a--) begin
            cyc(1, 8'(a), 0, 0, 8'h00, "R4");
            cyc(0, 8'h00, 0, 1, 8'h00, "R6");
        end

        // R3: nibble boundaries of both decoders
        cyc(1, 8'h01, 0, 0, 8'h00, "R3"); cyc(0, 8'h00, 0, 1, 8'h00, "R3");
        cyc(1, 8'h0F, 0, 0, 8'h00, "R3"); cyc(0, 8'h00, 0, 1, 8'h00, "R3");
        cyc(1, 8'h10, 0, 0, 8'h00, "R3"); cyc(0, 8'h00, 0, 1, 8'h00, "R3");
        cyc(1, 8'hF0, 0, 0, 8'h00, "R3"); cyc(0, 8'h00, 0, 1, 8'h00, "R3");

        // R2: addr_in moves without load, selection stays
        cyc(1, 8'h33, 0, 0, 8'h00, "R2");
        cyc(0, 8'h99, 0, 1, 8'h00, "R2");
        cyc(0, 8'hC4, 0, 1, 8'h00, "R2");

        // R7: stored nonzero byte, read strobe low
        cyc(0, 8'h00, 0, 0, 8'h00, "R7");
        cyc(0, 8'h00, 0, 0, 8'hEE, "R7");

        // R9: io_in toggles with io_set low, cell unchanged
        cyc(0, 8'h00, 0, 0, 8'hFF, "R9");
        cyc(0, 8'h00, 0, 0, 8'h00, "R9");
        cyc(0, 8'h00, 0, 1, 8'hFF, "R9");

        // R8: read and write together
        cyc(0, 8'h00, 1, 1, 8'hC3, "R8");
        cyc(0, 8'h00, 0, 1, 8'h00, "R8");

        // R10: load and write in the same cycle hit the old address
        cyc(1, 8'h20, 1, 0, 8'h77, "R10");
        cyc(0, 8'h00, 0, 1, 8'h00, "R10");
        cyc(1, 8'h33, 0, 0, 8'h00, "R10");
        cyc(0, 8'h00, 0, 1, 8'h00, "R10");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule